// File: doc/BRIEF.md
# Instruction-Cycle Timer/Counter with Phase-Qualified Input Sampling

This block is an 8-bit count register for a small processor core whose instruction cycle is built from four oscillator phases (Q1 to Q4). A free-running phase counter inside the block produces those phases. One instruction cycle therefore lasts four clocks. The register advances either once per instruction cycle or on edges of a slow input. That input is either an external pin with selectable polarity or the output of a separate prescaler that sits outside this block.

A slow input is never used directly. It is sampled at the end of the Q2 and Q4 clocks. A rise between two consecutive samples is held as a pending event, and the event is applied at the end of the next Q4 clock. The CPU may write the register at any clock. A write overrides any increment in the same clock. It also blocks counting for the next two instruction cycles, so that the written value stays visible for that time. When the count wraps from all ones to zero, a one-clock overflow flag is raised.

Top module: `icyc_timer`

## Requirements
- R1: While reset is asserted and in the first clock after its release, count_o is 0x00, phase_o is 0 and ovf_o is 0.
- R2: phase_o steps through 0,1,2,3,0,… once per clock. The values 0 to 3 stand for Q1 to Q4, and the last clock of an instruction cycle is the one with phase_o = 3.
- R3: With scaled_sel_i = 0 and src_ext_i = 0, count_o increases by one at the clock edge that ends each phase-3 clock, and at no other edge.
- R4: With scaled_sel_i = 0, src_ext_i = 1 and edge_fall_i = 0, the pin level is sampled at the edges ending the phase-1 and phase-3 clocks. A 0-to-1 change between consecutive samples adds one to the count at the end of the next phase-3 clock that comes after the sample that saw it, so a rise seen by a phase-3 sample counts one instruction cycle later.
- R5: With edge_fall_i = 1 in external mode, falling pin edges are counted in the same way and rising edges are not.
- R6: With scaled_sel_i = 1, scaled_tick_i is sampled and counted on its rising edges exactly as in R4. src_ext_i, edge_fall_i and ext_pin_i have no effect on the count.
- R7: A high level that no sample sees, for example a pin pulse lasting only a phase-0 clock, adds nothing to the count.
- R8: When wr_en_i is high at a clock edge, count_o takes wr_data_i at that edge, even if an increment was due at the same edge.
- R9: After a write, the increments of the next two phase-3 edges are dropped, including pending input events. Counting resumes at the third phase-3 edge.
- R10: An increment from 0xFF gives 0x00, and ovf_o is high for exactly the one clock that follows that edge. A write never raises ovf_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock, one phase per period |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_ext_i | input | 1 | 1 = count pin edges, 0 = count instruction cycles |
| edge_fall_i | input | 1 | 1 = falling pin edges counted, 0 = rising |
| scaled_sel_i | input | 1 | 1 = count rising edges of scaled_tick_i |
| scaled_tick_i | input | 1 | Output of the external prescaler |
| ext_pin_i | input | 1 | External count pin |
| wr_en_i | input | 1 | CPU write strobe |
| wr_data_i | input | 8 | CPU write value |
| count_o | output | 8 | Current count value |
| phase_o | output | 2 | Current phase, 0..3 = Q1..Q4 |
| ovf_o | output | 1 | One-clock wrap flag |

## Verification
The cycle that matters is a phase-3 clock where a CPU write lands on the same edge as an increment, which can be a timer tick or a pending pin event. The bench places writes at each of the four phases, and in particular at phase 3 with an increment due. It also places writes just below the wrap point. A reference model in the bench predicts the result on every clock. Directed checks confirm that the written value wins, that it then stays fixed for two instruction cycles, and that an overflow appears only from a genuine increment.

// File: rtl/icyc_pkg.sv
package icyc_pkg;
  typedef enum logic [1:0] {
    PH_Q1 = 2'd0,
    PH_Q2 = 2'd1,
    PH_Q3 = 2'd2,
    PH_Q4 = 2'd3
  } phase_e;
endpackage

// File: rtl/icyc_phase_gen.sv
module icyc_phase_gen
  import icyc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  output phase_e phase_o
);
  phase_e phase_q;
  phase_e phase_d;

  always_comb begin
    phase_d = phase_e'(phase_q + 2'd1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_Q1;
    else        phase_q <= phase_d;
  end

  assign phase_o = phase_q;

  // R2
  phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_Q4) |=> (phase_q == PH_Q1));
endmodule

// File: rtl/icyc_input_sync.sv
module icyc_input_sync
  import icyc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  phase_e phase_i,
  input  logic   level_i,
  output logic   evt_o
);
  logic samp_q, samp_d;
  logic pend_q, pend_d;
  logic samp_en;
  logic rise;

  always_comb begin
    samp_en = (phase_i == PH_Q2) || (phase_i == PH_Q4);
    rise    = level_i & ~samp_q;
    samp_d  = samp_q;
    pend_d  = pend_q;
    if (samp_en) begin
      samp_d = level_i;
      if (phase_i == PH_Q4) pend_d = rise;
      else                  pend_d = pend_q | rise;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      samp_q <= samp_d;
      pend_q <= pend_d;
    end
  end

  assign evt_o = (phase_i == PH_Q4) & pend_q;

  // R4
  samp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_i == PH_Q1 || phase_i == PH_Q3) |=> $stable(samp_q));

  // R7
  pend_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $rose(samp_q));
endmodule

// File: rtl/icyc_count_core.sv
module icyc_count_core
  import icyc_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int INHIBIT_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  phase_e           phase_i,
  input  logic             inc_req_i,
  input  logic             wr_en_i,
  input  logic [WIDTH-1:0] wr_data_i,
  output logic [WIDTH-1:0] count_o,
  output logic             ovf_o
);
  localparam int INH_W = $clog2(INHIBIT_CYC + 1);
  localparam logic [INH_W-1:0] INH_LOAD = INH_W'(INHIBIT_CYC);

  logic [WIDTH-1:0] count_q, count_d;
  logic [INH_W-1:0] inh_q, inh_d;
  logic             ovf_q, ovf_d;
  logic             is_q4;
  logic             fire;

  always_comb begin
    is_q4   = (phase_i == PH_Q4);
    fire    = inc_req_i & is_q4 & (inh_q == '0);
    count_d = count_q;
    inh_d   = inh_q;
    ovf_d   = 1'b0;
    if (is_q4 && inh_q != '0) inh_d = inh_q - 1'b1;
    if (wr_en_i) begin
      count_d = wr_data_i;
      inh_d   = INH_LOAD;
    end else if (fire) begin
      count_d = count_q + 1'b1;
      ovf_d   = &count_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      inh_q   <= '0;
      ovf_q   <= 1'b0;
    end else begin
      count_q <= count_d;
      inh_q   <= inh_d;
      ovf_q   <= ovf_d;
    end
  end

  assign count_o = count_q;
  assign ovf_o   = ovf_q;

  // R3
  q4_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_en_i) && $past(phase_i) != PH_Q4) |-> $stable(count_q));

  // R8
  write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en_i) |-> (count_q == $past(wr_data_i)));

  // R9
  inhibit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inh_q != '0 && is_q4 && !wr_en_i) |=> $stable(count_q));

  // R10
  ovf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> (count_q == '0));

  // R10
  ovf_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> !ovf_q);

  // R3
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en_i) |-> (count_q == $past(count_q) || count_q == $past(count_q) + 1'b1));
endmodule

// File: rtl/icyc_timer.sv
module icyc_timer
  import icyc_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int INHIBIT_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_ext_i,
  input  logic             edge_fall_i,
  input  logic             scaled_sel_i,
  input  logic             scaled_tick_i,
  input  logic             ext_pin_i,
  input  logic             wr_en_i,
  input  logic [WIDTH-1:0] wr_data_i,
  output logic [WIDTH-1:0] count_o,
  output logic [1:0]       phase_o,
  output logic             ovf_o
);
  phase_e phase;
  logic   level;
  logic   use_evt;
  logic   evt;
  logic   inc_req;

  always_comb begin
    level   = scaled_sel_i ? scaled_tick_i : (ext_pin_i ^ edge_fall_i);
    use_evt = scaled_sel_i | src_ext_i;
    inc_req = use_evt ? evt : 1'b1;
  end

  icyc_phase_gen u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .phase_o (phase)
  );

  icyc_input_sync u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .phase_i (phase),
    .level_i (level),
    .evt_o   (evt)
  );

  icyc_count_core #(
    .WIDTH       (WIDTH),
    .INHIBIT_CYC (INHIBIT_CYC)
  ) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase_i   (phase),
    .inc_req_i (inc_req),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .count_o   (count_o),
    .ovf_o     (ovf_o)
  );

  assign phase_o = phase;
endmodule

// File: tb/icyc_timer_bench.sv
`timescale 1ns/1ps
module icyc_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       src_ext = 1'b0, edge_fall = 1'b0, scaled_sel = 1'b0;
  logic       scaled_tick = 1'b0, ext_pin = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] count;
  logic [1:0] phase;
  logic       ovf;

  int    vectors = 0;
  int    fails = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  // reference model state
  int m_ph, m_cnt, m_samp, m_pend, m_inh, m_ovf;

  always #4 clk = ~clk;

  icyc_timer u_icyc_timer (
    .clk           (clk),
    .rst_n         (rst_n),
    .src_ext_i     (src_ext),
    .edge_fall_i   (edge_fall),
    .scaled_sel_i  (scaled_sel),
    .scaled_tick_i (scaled_tick),
    .ext_pin_i     (ext_pin),
    .wr_en_i       (wr_en),
    .wr_data_i     (wr_data),
    .count_o       (count),
    .phase_o       (phase),
    .ovf_o         (ovf)
  );

  task automatic chk(string tag, int got, int exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; m_samp = 0; m_pend = 0; m_inh = 0; m_ovf = 0;
    end else begin
      int lvl, ev, inc, nov;
      lvl = scaled_sel ? int'(scaled_tick) : int'(ext_pin ^ edge_fall);
      ev = 0;
      if (m_ph == 1) begin
        if (lvl == 1 && m_samp == 0) m_pend = 1;
        m_samp = lvl;
      end else if (m_ph == 3) begin
        ev = m_pend;
        m_pend = (lvl == 1 && m_samp == 0) ? 1 : 0;
        m_samp = lvl;
      end
      inc = 0;
      if (m_ph == 3) begin
        inc = (scaled_sel || src_ext) ? ev : 1;
        if (m_inh > 0) begin
          inc = 0;
          m_inh--;
        end
      end
      nov = 0;
      if (wr_en) begin
        m_cnt = wr_data;
        m_inh = 2;
      end else if (inc == 1) begin
        if (m_cnt == 255) nov = 1;
        m_cnt = (m_cnt + 1) % 256;
      end
      m_ovf = nov;
      m_ph = (m_ph + 1) % 4;
    end
  end

  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      chk(cur_req, count, m_cnt);
      chk("R2 phase", phase, m_ph);
      chk("R10 ovf", ovf, m_ovf);
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_phase(int p);
    while (phase != p[1:0]) @(negedge clk);
  endtask

  task automatic do_write(logic [7:0] v);
    wr_en = 1'b1;
    wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic int diff8(logic [7:0] a, logic [7:0] b);
    return int'(8'(a - b));
  endfunction

  initial begin
    repeat (10000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: got 0 expected 1 (run completed)");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] c0;
    // R1 reset state
    tick(3);
    chk("R1 count in reset", count, 0);
    chk("R1 phase in reset", phase, 0);
    chk("R1 ovf in reset", ovf, 0);
    rst_n = 1'b1;
    #1;
    chk("R1 count after release", count, 0);
    chk("R1 phase after release", phase, 0);

    // R3 timer mode
    cur_req = "R3";
    c0 = count;
    tick(40);
    chk("R3 ten cycles", diff8(count, c0), 10);

    // R8 writes at each phase
    cur_req = "R8";
    for (int k = 0; k < 4; k++) begin
      wait_phase(k);
      do_write(8'h40 + 8'(k));
      chk("R8 write value", count, 32'h40 + k);
      tick(13);
    end

    // R9 inhibit window after a write at Q4
    cur_req = "R9";
    wait_phase(3);
    do_write(8'h77);
    chk("R8 write over increment", count, 8'h77);
    tick(8);
    chk("R9 held two cycles", count, 8'h77);
    tick(4);
    chk("R9 resumes", count, 8'h78);

    // R10 wrap
    cur_req = "R10";
    wait_phase(3);
    do_write(8'hFD);
    tick(20);
    chk("R10 wrap count", count, 0);
    chk("R10 ovf high", ovf, 1);
    tick(1);
    chk("R10 ovf one clock", ovf, 0);
    wait_phase(2);
    do_write(8'hFF);
    chk("R10 write no ovf", ovf, 0);
    tick(20);

    // R4 external rising edges
    cur_req = "R4";
    src_ext = 1'b1;
    ext_pin = 1'b0;
    tick(16);
    c0 = count;
    for (int i = 0; i < 8; i++) begin
      ext_pin = 1'b1; tick(8);
      ext_pin = 1'b0; tick(8);
    end
    tick(12);
    chk("R4 eight rises", diff8(count, c0), 8);
    for (int i = 0; i < 30; i++) begin
      ext_pin = ~ext_pin; tick(3);
    end
    for (int i = 0; i < 20; i++) begin
      ext_pin = ~ext_pin; tick(5);
    end
    ext_pin = 1'b0;
    tick(12);

    // R7 unsampled short pulse
    cur_req = "R7";
    wait_phase(0);
    c0 = count;
    ext_pin = 1'b1;
    tick(1);
    ext_pin = 1'b0;
    tick(12);
    chk("R7 short pulse ignored", count, c0);

    // R5 falling edges
    cur_req = "R5";
    ext_pin = 1'b1;
    tick(8);
    edge_fall = 1'b1;
    tick(16);
    c0 = count;
    for (int i = 0; i < 8; i++) begin
      ext_pin = 1'b0; tick(8);
      ext_pin = 1'b1; tick(8);
    end
    tick(12);
    chk("R5 eight falls", diff8(count, c0), 8);

    // R6 prescaler input, other selects toggled
    cur_req = "R6";
    scaled_sel = 1'b1;
    scaled_tick = 1'b0;
    tick(16);
    c0 = count;
    for (int i = 0; i < 6; i++) begin
      scaled_tick = 1'b1;
      src_ext = ~src_ext; ext_pin = ~ext_pin;
      tick(4);
      scaled_tick = 1'b0;
      edge_fall = ~edge_fall; ext_pin = ~ext_pin;
      tick(4);
    end
    tick(12);
    chk("R6 six scaled ticks", diff8(count, c0), 6);

    // mixed stimulus, compared against model every clock
    cur_req = "R9 mixed";
    for (int i = 0; i < 600; i++) begin
      logic [31:0] r;
      r = $urandom;
      ext_pin = r[0];
      scaled_tick = r[1];
      if (r[7:4] == 4'd0) scaled_sel = ~scaled_sel;
      if (r[11:8] == 4'd0) src_ext = ~src_ext;
      if (r[15:12] == 4'd0) edge_fall = ~edge_fall;
      wr_en = (r[20:16] == 5'd0);
      wr_data = r[31:24] | 8'hF0;
      tick(1);
    end
    wr_en = 1'b0;
    tick(8);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule